// File: doc/BRIEF.md
# Page-Table Address Translator

This block maps an 18-bit logical address onto a 16-bit physical address using a direct, single-level page table of 64 entries kept in registers. The upper six bits of the logical address pick a table entry. The lower twelve bits pass through unchanged as the offset inside a 4K page. Each entry has a resident flag and a 4-bit frame number. When the flag is clear, the block raises a fault instead of producing an address.

An operating-system agent installs and evicts mappings through a write port that updates one entry per cycle. The block also keeps a recency order over the 16 physical frames. It always presents the least recently used frame as the suggested victim for the next page load.

Top module: `page_xlate`

## Requirements
- R1: On a cycle with `req_i` high, the next cycle shows `valid_o`=1 and `paddr_o` = {frame of entry `laddr_i[17:12]`, `laddr_i[11:0]`} when that entry is resident.
- R2: With page 3 mapped resident to frame 15, logical 0x03DFF translates to physical 0x0FDFF (16 bits: 0xFDFF).
- R3: A request whose entry is not resident gives `fault_o`=1, `valid_o`=0 and `paddr_o`=0 in the next cycle.
- R4: A cycle with `req_i` low gives `valid_o`=0, `fault_o`=0 and `paddr_o`=0 in the next cycle.
- R5: A write (`wr_i`=1) stores `wr_avail_i` and `wr_frame_i` into entry `wr_page_i` at the clock edge. Requests in later cycles see the new contents.
- R6: When a write and a request target the same page in one cycle, the translation uses the entry as it was before the write.
- R7: Reset clears every resident flag. It sets the recency order to frame 0 oldest up to frame 15 newest, so `victim_o`=0.
- R8: A successful translation makes its frame the most recently used. From the next cycle, `victim_o` names the least recently used frame, which is never the frame just used.
- R9: A faulting translation, an idle cycle or a table write leaves the recency order and `victim_o` unchanged.
- R10: `valid_o` and `fault_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request strobe |
| laddr_i | input | 18 | Logical address |
| wr_i | input | 1 | Table write enable |
| wr_page_i | input | 6 | Entry to write |
| wr_avail_i | input | 1 | Resident flag to store |
| wr_frame_i | input | 4 | Frame number to store |
| paddr_o | output | 16 | Physical address, zero unless valid |
| valid_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Page not resident |
| victim_o | output | 4 | Least recently used frame |

## Verification
A translation and a table write can land on the same entry in the same cycle. Directed steps install page 5, then request page 5 while rewriting it to another frame. The result is judged against the old frame, and the following request against the new one. The random phase also overlaps writes and requests on a small page set to hit this case often. A second overlap is a fault and a recency update in the same cycle. The bench checks that `victim_o` holds still whenever the request faults.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned PAGE_W_D  = 6;
  localparam int unsigned OFFS_W_D  = 12;
  localparam int unsigned FRAME_W_D = 4;

  typedef enum logic [1:0] {
    XL_IDLE  = 2'd0,
    XL_HIT   = 2'd1,
    XL_FAULT = 2'd2
  } xl_res_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int unsigned PAGE_W  = 6,
  parameter int unsigned FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PAGE_W-1:0]  wr_page_i,
  input  logic               wr_avail_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  input  logic [PAGE_W-1:0]  rd_page_i,
  output logic               rd_avail_o,
  output logic [FRAME_W-1:0] rd_frame_o
);
  localparam int unsigned NPAGES = 1 << PAGE_W;

  logic [NPAGES-1:0] avail_q;
  logic [FRAME_W-1:0] frame_q [NPAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= '0;
      for (int i = 0; i < int'(NPAGES); i++) frame_q[i] <= '0;
    end else if (wr_en_i) begin
      avail_q[wr_page_i] <= wr_avail_i;
      frame_q[wr_page_i] <= wr_frame_i;
    end
  end

  // combinational read sees pre-write contents
  assign rd_avail_o = avail_q[rd_page_i];
  assign rd_frame_o = frame_q[rd_page_i];
endmodule

// File: rtl/pgx_lru.sv
module pgx_lru #(
  parameter int unsigned FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_i,
  input  logic [FRAME_W-1:0] touch_frame_i,
  output logic [FRAME_W-1:0] victim_o
);
  localparam int unsigned NFR = 1 << FRAME_W;

  // ord_q[0] oldest, ord_q[NFR-1] newest
  logic [FRAME_W-1:0] ord_q [NFR];
  logic [FRAME_W-1:0] ord_d [NFR];
  logic [NFR-1:0]     hit;
  logic [NFR-1:0]     shift;

  for (genvar g = 0; g < int'(NFR); g++) begin : g_pos
    assign hit[g] = (ord_q[g] == touch_frame_i);
    if (g == 0) begin : g_first
      assign shift[g] = hit[g];
    end else begin : g_rest
      assign shift[g] = shift[g-1] | hit[g];
    end
  end

  always_comb begin
    for (int i = 0; i < int'(NFR) - 1; i++)
      ord_d[i] = (touch_i && shift[i]) ? ord_q[i+1] : ord_q[i];
    ord_d[NFR-1] = touch_i ? touch_frame_i : ord_q[NFR-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NFR); i++) ord_q[i] <= FRAME_W'(i);
    end else begin
      for (int i = 0; i < int'(NFR); i++) ord_q[i] <= ord_d[i];
    end
  end

  assign victim_o = ord_q[0];
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pgx_pkg::*;
#(
  parameter int unsigned PAGE_W  = PAGE_W_D,
  parameter int unsigned OFFS_W  = OFFS_W_D,
  parameter int unsigned FRAME_W = FRAME_W_D,
  localparam int unsigned LA_W   = PAGE_W + OFFS_W,
  localparam int unsigned PA_W   = FRAME_W + OFFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [LA_W-1:0]    laddr_i,
  input  logic               wr_i,
  input  logic [PAGE_W-1:0]  wr_page_i,
  input  logic               wr_avail_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  output logic [PA_W-1:0]    paddr_o,
  output logic               valid_o,
  output logic               fault_o,
  output logic [FRAME_W-1:0] victim_o
);
  logic               ent_avail;
  logic [FRAME_W-1:0] ent_frame;
  logic               hit;
  xl_res_e            res_q;
  logic [PA_W-1:0]    paddr_q;

  pgx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_i),
    .wr_page_i  (wr_page_i),
    .wr_avail_i (wr_avail_i),
    .wr_frame_i (wr_frame_i),
    .rd_page_i  (laddr_i[LA_W-1:OFFS_W]),
    .rd_avail_o (ent_avail),
    .rd_frame_o (ent_frame)
  );

  assign hit = req_i && ent_avail;

  pgx_lru #(.FRAME_W(FRAME_W)) u_lru (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .touch_i       (hit),
    .touch_frame_i (ent_frame),
    .victim_o      (victim_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= XL_IDLE;
      paddr_q <= '0;
    end else if (!req_i) begin
      res_q   <= XL_IDLE;
      paddr_q <= '0;
    end else if (ent_avail) begin
      res_q   <= XL_HIT;
      paddr_q <= {ent_frame, laddr_i[OFFS_W-1:0]};
    end else begin
      res_q   <= XL_FAULT;
      paddr_q <= '0;
    end
  end

  assign paddr_o = paddr_q;
  assign valid_o = (res_q == XL_HIT);
  assign fault_o = (res_q == XL_FAULT);
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
  parameter int unsigned OFFS_W  = 12,
  parameter int unsigned FRAME_W = 4,
  localparam int unsigned PA_W   = FRAME_W + OFFS_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [OFFS_W-1:0]  offs_i,
  input logic [PA_W-1:0]    paddr_o,
  input logic               valid_o,
  input logic               fault_o,
  input logic [FRAME_W-1:0] victim_o
);
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));

  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !fault_o && paddr_o == '0));

  a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!valid_o || paddr_o[OFFS_W-1:0] == $past(offs_i)));

  a_r3_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (paddr_o == '0 && !valid_o));

  a_r8_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (victim_o != paddr_o[PA_W-1:OFFS_W]));

  a_r9_fault_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(victim_o));
endmodule

bind page_xlate pgx_checker #(.OFFS_W(OFFS_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .offs_i   (laddr_i[OFFS_W-1:0]),
  .paddr_o  (paddr_o),
  .valid_o  (valid_o),
  .fault_o  (fault_o),
  .victim_o (victim_o)
);

// File: tb/page_xlate_test.sv
module page_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [17:0] laddr_i = '0;
  logic        wr_i = 1'b0;
  logic [5:0]  wr_page_i = '0;
  logic        wr_avail_i = 1'b0;
  logic [3:0]  wr_frame_i = '0;
  logic [15:0] paddr_o;
  logic        valid_o, fault_o;
  logic [3:0]  victim_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic       m_av [64];
  logic [3:0] m_fr [64];
  logic [3:0] m_ord [16];

  always #4 clk_i = ~clk_i;

  page_xlate uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .laddr_i(laddr_i),
    .wr_i(wr_i), .wr_page_i(wr_page_i), .wr_avail_i(wr_avail_i),
    .wr_frame_i(wr_frame_i), .paddr_o(paddr_o), .valid_o(valid_o),
    .fault_o(fault_o), .victim_o(victim_o)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=0x%0h exp=0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic model_touch(input logic [3:0] f);
    int p = 0;
    for (int i = 0; i < 16; i++) if (m_ord[i] == f) p = i;
    for (int i = p; i < 15; i++) m_ord[i] = m_ord[i+1];
    m_ord[15] = f;
  endtask

  // called at a negedge; drives, waits one cycle, checks, updates model
  task automatic step(input string tag, input logic rq, input logic [17:0] la,
                      input logic wr, input logic [5:0] wp, input logic wa,
                      input logic [3:0] wf);
    logic        e_v, e_f;
    logic [15:0] e_pa;
    logic [5:0]  pg;
    pg = la[17:12];
    e_v = rq && m_av[pg];
    e_f = rq && !m_av[pg];
    e_pa = e_v ? {m_fr[pg], la[11:0]} : 16'h0;
    req_i = rq; laddr_i = la; wr_i = wr; wr_page_i = wp;
    wr_avail_i = wa; wr_frame_i = wf;
    if (e_v) model_touch(m_fr[pg]);
    if (wr) begin m_av[wp] = wa; m_fr[wp] = wf; end
    @(negedge clk_i);
    chk(tag, "valid", int'(valid_o), int'(e_v));
    chk(tag, "fault", int'(fault_o), int'(e_f));
    chk(tag, "paddr", int'(paddr_o), int'(e_pa));
    chk(tag, "victim", int'(victim_o), int'(m_ord[0]));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin m_av[i] = 1'b0; m_fr[i] = '0; end
    for (int i = 0; i < 16; i++) m_ord[i] = 4'(i);
    repeat (3) @(negedge clk_i);
    chk("R7", "reset valid", int'(valid_o), 0);
    chk("R7", "reset fault", int'(fault_o), 0);
    chk("R7", "reset victim", int'(victim_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7: every page absent after reset
    step("R7", 1, 18'h00000, 0, 0, 0, 0);
    step("R7", 1, 18'h3F123, 0, 0, 0, 0);
    // R4 idle
    step("R4", 0, 18'h03DFF, 0, 0, 0, 0);
    // R5 install and R2 example
    step("R5", 0, 0, 1, 6'd3, 1, 4'd15);
    step("R2", 1, 18'h03DFF, 0, 0, 0, 0);
    chk("R2", "example paddr", int'(paddr_o), 16'hFDFF);
    // R8 recency
    step("R5", 0, 0, 1, 6'd0, 1, 4'd0);
    step("R5", 0, 0, 1, 6'd1, 1, 4'd1);
    step("R8", 1, 18'h00ABC, 0, 0, 0, 0);
    chk("R8", "victim after frame0 use", int'(victim_o), 1);
    step("R8", 1, 18'h01001, 0, 0, 0, 0);
    chk("R8", "victim after frame1 use", int'(victim_o), 2);
    // R9 fault does not age
    step("R9", 1, 18'h20000, 0, 0, 0, 0);
    chk("R9", "victim after fault", int'(victim_o), 2);
    // R3 evict then fault
    step("R3", 0, 0, 1, 6'd1, 0, 4'd1);
    step("R3", 1, 18'h01FFF, 0, 0, 0, 0);
    // R6 same-cycle write and request
    step("R6", 0, 0, 1, 6'd5, 1, 4'd2);
    step("R6", 1, 18'h05777, 1, 6'd5, 1, 4'd9);
    step("R6", 1, 18'h05777, 0, 0, 0, 0);
    step("R6", 1, 18'h05010, 1, 6'd5, 0, 4'd9);
    step("R6", 1, 18'h05010, 0, 0, 0, 0);
    // random phase, small page set to force overlap (R1 R5 R6 R8 R9 R10)
    for (int n = 0; n < 4000; n++) begin
      logic [17:0] la;
      logic [5:0]  wp;
      la = {2'b00, 4'($urandom_range(0, 15)), 12'($urandom)};
      if ($urandom_range(0, 7) == 0) la[17:12] = 6'($urandom);
      wp = 6'($urandom_range(0, 15));
      step("R1", 1'($urandom_range(0, 3) != 0), la,
           1'($urandom_range(0, 2) == 0), wp,
           1'($urandom_range(0, 3) != 0), 4'($urandom));
      if (valid_o && fault_o) chk("R10", "both flags", 1, 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule